// File: doc/BRIEF.md
# Read Burst Regrouper

This block sits on the requester side of a read data channel whose beats come back tagged with a transaction ID. Read requests are recorded as they are accepted on the address channel. The table keeps the request ID and the burst length for each one. Returning beats are steered into a per-slot buffer by their ID. Beats of one ID arrive in order. Beats of different IDs may be mixed freely, and whole transactions may finish in any order relative to their requests.

When the final beat of a burst arrives with its last marker at the expected position, the slot is marked complete. The whole burst is then offered to the requester in one transfer, labelled with the ID the request carried. Only one request per ID may be outstanding, and new requests stall while the table is full. The read ID space is separate from any write ID space, so ID values need no coordination with writes. A beat whose ID owns no waiting slot, or a last marker at the wrong position, sets a sticky error flag.

Top module: `rd_burst_regroup`

## Requirements
- R1: After reset no burst is offered (`out_valid` low), the error flag is low, and `ar_ready` is high for any ID.
- R2: A request is taken in a cycle with `ar_valid` and `ar_ready` both high. `ar_ready` stays low while all ENTRIES slots are occupied, including completed slots not yet handed over.
- R3: `ar_ready` is low while `ar_id` equals the ID of any occupied slot, so at most one request per ID is outstanding.
- R4: Beat k (counting from 0) of a burst appears in `out_data[k*DATA_W +: DATA_W]`. Positions at or beyond the burst length read as zero.
- R5: Beats of different IDs may be interleaved cycle by cycle. Each burst is rebuilt from its own beats in arrival order, and bursts are handed over in completion order when the requester is always ready.
- R6: In the cycle after the beat that carries `r_last` as beat number `ar_len+1`, `out_valid` rises with `out_id` equal to the request ID and `out_beats` equal to `ar_len+1`. It stays offered until `out_valid && out_ready`, and the slot is free in the next cycle.
- R7: Requests take the lowest-numbered free slot. When several slots hold completed bursts, the one in the lowest-numbered slot is offered first.
- R8: A beat whose `r_id` matches no slot still awaiting data is discarded, and `err_sticky` is high from the next cycle.
- R9: A beat carrying `r_last` before beat number `ar_len+1`, or beat number `ar_len+1` arriving without `r_last`, sets `err_sticky`. That burst is discarded and never offered, and its slot is freed.
- R10: Once set, `err_sticky` stays high until reset, while normal bursts keep flowing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ar_valid | input | 1 | Read request present |
| ar_ready | output | 1 | Request can be accepted |
| ar_id | input | ID_W | Request ID |
| ar_len | input | LEN_W | Beats in burst minus one |
| r_valid | input | 1 | Read data beat present (always accepted) |
| r_id | input | ID_W | ID of the beat |
| r_data | input | DATA_W | Beat payload |
| r_last | input | 1 | Final beat marker |
| out_valid | output | 1 | A complete burst is offered |
| out_ready | input | 1 | Requester takes the offered burst |
| out_id | output | ID_W | ID of the offered burst |
| out_beats | output | CNT_W | Beat count of the offered burst |
| out_data | output | MAX_BEATS*DATA_W | Burst payload, beat 0 in the low bits |
| err_sticky | output | 1 | Sticky protocol error |

## Verification
The bench builds the block with its defaults: ENTRIES=4, MAX_BEATS=4, ID_W=4 and DATA_W=32. Four slots fill in four requests, so the full-table stall and the lowest-slot choice among four completed bursts are both reached directly. The four-beat ceiling allows bursts of one, two and three beats, which leaves zero padding visible in the upper beat positions. Sixteen IDs leave spare values for stray beats.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

    // Outcome of one incoming read data beat
    typedef enum logic [1:0] {
        BEAT_NONE,
        BEAT_STORE,
        BEAT_DONE,
        BEAT_BAD
    } beat_kind_e;

endpackage

// File: rtl/rbr_id_match.sv
module rbr_id_match #(
    parameter int N    = 4,
    parameter int ID_W = 4
) (
    input  logic [N-1:0]           mask,
    input  logic [N-1:0][ID_W-1:0] ids,
    input  logic [ID_W-1:0]        key,
    output logic [N-1:0]           hit
);

    // One comparator per slot; masked slots never hit
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = mask[g] && (ids[g] == key);
    end

endmodule

// File: rtl/rbr_lowest_pick.sv
module rbr_lowest_pick #(
    parameter  int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/rd_burst_regroup.sv
module rd_burst_regroup
    import rbr_pkg::*;
#(
    parameter  int ENTRIES   = 4,
    parameter  int ID_W      = 4,
    parameter  int DATA_W    = 32,
    parameter  int MAX_BEATS = 4,
    localparam int LEN_W     = $clog2(MAX_BEATS),
    localparam int CNT_W     = $clog2(MAX_BEATS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ar_valid,
    output logic                        ar_ready,
    input  logic [ID_W-1:0]             ar_id,
    input  logic [LEN_W-1:0]            ar_len,
    input  logic                        r_valid,
    input  logic [ID_W-1:0]             r_id,
    input  logic [DATA_W-1:0]           r_data,
    input  logic                        r_last,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [ID_W-1:0]             out_id,
    output logic [CNT_W-1:0]            out_beats,
    output logic [MAX_BEATS*DATA_W-1:0] out_data,
    output logic                        err_sticky
);

    localparam int IDX_W = $clog2(ENTRIES);

    typedef logic [MAX_BEATS-1:0][DATA_W-1:0] beats_t;

    typedef struct packed {
        logic             vld;
        logic             done;
        logic [ID_W-1:0]  id;
        logic [CNT_W-1:0] need;
        logic [CNT_W-1:0] got;
        beats_t           beats;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
        logic                err;
    } state_t;

    state_t st_q, st_d;

    // Per-slot views of the table
    logic [ENTRIES-1:0]           slot_vld;
    logic [ENTRIES-1:0]           slot_free;
    logic [ENTRIES-1:0]           slot_open;
    logic [ENTRIES-1:0]           slot_done;
    logic [ENTRIES-1:0][ID_W-1:0] slot_id;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            slot_vld[i]  = st_q.slot[i].vld;
            slot_free[i] = !st_q.slot[i].vld;
            slot_open[i] = st_q.slot[i].vld && !st_q.slot[i].done;
            slot_done[i] = st_q.slot[i].vld && st_q.slot[i].done;
            slot_id[i]   = st_q.slot[i].id;
        end
    end

    // ID lookups: request ID against every occupied slot, beat ID against
    // every slot still waiting for data
    logic [ENTRIES-1:0] busy_hit;
    logic [ENTRIES-1:0] r_hit;

    rbr_id_match #(.N(ENTRIES), .ID_W(ID_W)) u_busy_match (
        .mask (slot_vld),
        .ids  (slot_id),
        .key  (ar_id),
        .hit  (busy_hit)
    );

    rbr_id_match #(.N(ENTRIES), .ID_W(ID_W)) u_beat_match (
        .mask (slot_open),
        .ids  (slot_id),
        .key  (r_id),
        .hit  (r_hit)
    );

    // Lowest-index selectors: free slot, beat owner, completed burst
    logic [IDX_W-1:0] free_idx, r_idx, out_idx;
    logic             free_any, r_any, out_any;

    rbr_lowest_pick #(.N(ENTRIES)) u_free_pick (
        .req (slot_free),
        .idx (free_idx),
        .any (free_any)
    );

    rbr_lowest_pick #(.N(ENTRIES)) u_beat_pick (
        .req (r_hit),
        .idx (r_idx),
        .any (r_any)
    );

    rbr_lowest_pick #(.N(ENTRIES)) u_out_pick (
        .req (slot_done),
        .idx (out_idx),
        .any (out_any)
    );

    beat_kind_e       beat_kind;
    logic [CNT_W-1:0] got_next;
    logic [CNT_W-1:0] need_sel;
    logic             hit_expected;

    always_comb begin
        st_d      = st_q;
        beat_kind = BEAT_NONE;
        ar_ready  = free_any && !(|busy_hit);

        // Request intake into the lowest free slot
        if (ar_valid && ar_ready) begin
            st_d.slot[free_idx].vld   = 1'b1;
            st_d.slot[free_idx].done  = 1'b0;
            st_d.slot[free_idx].id    = ar_id;
            st_d.slot[free_idx].need  = CNT_W'(ar_len) + CNT_W'(1);
            st_d.slot[free_idx].got   = '0;
            st_d.slot[free_idx].beats = '0;
        end

        // Beat steering and last-marker check
        got_next     = st_q.slot[r_idx].got + CNT_W'(1);
        hit_expected = (got_next == st_q.slot[r_idx].need);
        if (r_valid) begin
            if (!r_any) begin
                beat_kind = BEAT_BAD;
            end else if (r_last != hit_expected) begin
                beat_kind = BEAT_BAD;
            end else if (r_last) begin
                beat_kind = BEAT_DONE;
            end else begin
                beat_kind = BEAT_STORE;
            end
        end

        if (r_valid && r_any) begin
            st_d.slot[r_idx].beats[st_q.slot[r_idx].got[LEN_W-1:0]] = r_data;
            st_d.slot[r_idx].got = got_next;
            case (beat_kind)
                BEAT_DONE: st_d.slot[r_idx].done = 1'b1;
                BEAT_BAD:  st_d.slot[r_idx].vld  = 1'b0;
                default:   ;
            endcase
        end

        // Hand-over of the lowest completed slot
        if (out_any && out_ready) begin
            st_d.slot[out_idx].vld  = 1'b0;
            st_d.slot[out_idx].done = 1'b0;
        end

        st_d.err = st_q.err || (beat_kind == BEAT_BAD);
    end

    // Output view of the selected completed slot
    always_comb begin
        need_sel   = st_q.slot[out_idx].need;
        out_valid  = out_any;
        out_id     = st_q.slot[out_idx].id;
        out_beats  = need_sel;
        err_sticky = st_q.err;
        for (int b = 0; b < MAX_BEATS; b++) begin
            out_data[b*DATA_W +: DATA_W] =
                (CNT_W'(b) < need_sel) ? st_q.slot[out_idx].beats[b] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rbr_checker.sv
module rbr_checker #(
    parameter int ENTRIES   = 4,
    parameter int ID_W      = 4,
    parameter int CNT_W     = 3,
    parameter int MAX_BEATS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ar_valid,
    input logic               ar_ready,
    input logic [ID_W-1:0]    ar_id,
    input logic               r_valid,
    input logic [ENTRIES-1:0] r_hit,
    input logic [ENTRIES-1:0] slot_vld,
    input logic               out_valid,
    input logic               out_ready,
    input logic [CNT_W-1:0]   out_beats,
    input logic               err_sticky
);

    // R2: a fully occupied table refuses requests
    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (&slot_vld) |-> !ar_ready);

    // R3: an ID just accepted cannot be accepted again next cycle
    a_r3_no_repeat_id: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && ar_ready) |=> !(ar_valid && ar_ready && ar_id == $past(ar_id)));

    // R3: a beat has at most one owning slot
    a_r3_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> $onehot0(r_hit));

    // R6: an offered burst is not withdrawn before it is taken
    a_r6_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    // R6: offered beat count lies within the legal range
    a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_beats != '0 && out_beats <= CNT_W'(MAX_BEATS)));

    // R8: a beat without an owner raises the flag
    a_r8_stray_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_hit == '0) |=> err_sticky);

    // R10: the flag never clears outside reset
    a_r10_flag_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

endmodule

bind rd_burst_regroup rbr_checker #(
    .ENTRIES   (ENTRIES),
    .ID_W      (ID_W),
    .CNT_W     (CNT_W),
    .MAX_BEATS (MAX_BEATS)
) u_rbr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ar_valid   (ar_valid),
    .ar_ready   (ar_ready),
    .ar_id      (ar_id),
    .r_valid    (r_valid),
    .r_hit      (r_hit),
    .slot_vld   (slot_vld),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_beats  (out_beats),
    .err_sticky (err_sticky)
);

// File: tb/test_rd_burst_regroup.sv
`timescale 1ns/1ps
module test_rd_burst_regroup;

    localparam int E  = 4;
    localparam int IW = 4;
    localparam int DW = 32;
    localparam int MB = 4;
    localparam int LW = $clog2(MB);
    localparam int CW = $clog2(MB + 1);
    localparam int OW = MB * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ar_valid = 1'b0;
    logic          ar_ready;
    logic [IW-1:0] ar_id = '0;
    logic [LW-1:0] ar_len = '0;
    logic          r_valid = 1'b0;
    logic [IW-1:0] r_id = '0;
    logic [DW-1:0] r_data = '0;
    logic          r_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [IW-1:0] out_id;
    logic [CW-1:0] out_beats;
    logic [OW-1:0] out_data;
    logic          err_sticky;

    int checks = 0;
    int errors = 0;

    int            exp_id[$];
    int            exp_n[$];
    logic [OW-1:0] exp_data[$];

    always #2.5 clk = ~clk;

    rd_burst_regroup #(
        .ENTRIES(E), .ID_W(IW), .DATA_W(DW), .MAX_BEATS(MB)
    ) i_rd_burst_regroup (
        .clk(clk), .rst_n(rst_n),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len),
        .r_valid(r_valid), .r_id(r_id), .r_data(r_data), .r_last(r_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
        .out_beats(out_beats), .out_data(out_data), .err_sticky(err_sticky)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [OW-1:0] act, input logic [OW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] bval(input int id, input int k);
        return 32'hD000_0000 | DW'(id << 8) | DW'(k);
    endfunction

    task automatic push_exp(input int id, input int n);
        logic [OW-1:0] v = '0;
        for (int k = 0; k < n; k++) v[k*DW +: DW] = bval(id, k);
        exp_id.push_back(id);
        exp_n.push_back(n);
        exp_data.push_back(v);
    endtask

    // Scoreboard monitor: every hand-over must match the queue front
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_id.size() == 0) begin
                chk(1'b0, "R6 unexpected burst", OW'(out_id), '0);
            end else begin
                chk(out_id == IW'(exp_id[0]), "R5 R6 R7 burst id", OW'(out_id), OW'(exp_id[0]));
                chk(out_beats == CW'(exp_n[0]), "R6 beat count", OW'(out_beats), OW'(exp_n[0]));
                chk(out_data == exp_data[0], "R4 R5 burst data", out_data, exp_data[0]);
                void'(exp_id.pop_front());
                void'(exp_n.pop_front());
                void'(exp_data.pop_front());
            end
        end
    end

    task automatic to_drive();
        @(posedge clk); #1;
    endtask

    task automatic to_sample();
        @(negedge clk);
    endtask

    task automatic issue(input int id, input int len);
        ar_id = IW'(id); ar_len = LW'(len); ar_valid = 1'b1;
        #1;
        chk(ar_ready, "R2 request accepted", OW'(ar_ready), 1);
        @(posedge clk); #1;
        ar_valid = 1'b0;
    endtask

    task automatic beat(input int id, input int k, input bit last);
        r_valid = 1'b1; r_id = IW'(id); r_data = bval(id, k); r_last = last;
        @(posedge clk); #1;
        r_valid = 1'b0; r_last = 1'b0;
    endtask

    task automatic probe(input int id, input bit exp, input string tag);
        ar_id = IW'(id);
        #1;
        chk(ar_ready == exp, tag, OW'(ar_ready), OW'(exp));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        to_drive();
    endtask

    task automatic check_idle(input string tag);
        to_sample();
        chk(!out_valid, {tag, " no offer"}, OW'(out_valid), 0);
        chk(!err_sticky, {tag, " flag low"}, OW'(err_sticky), 0);
        to_drive();
        probe(9, 1'b1, {tag, " ready high"});
    endtask

    task automatic run_all();
        do_reset();
        check_idle("R1");

        // Single four-beat burst, timing of the offer
        push_exp(3, 4);
        issue(3, 3);
        beat(3, 0, 0); beat(3, 1, 0); beat(3, 2, 0); beat(3, 3, 1);
        to_sample();
        chk(out_valid, "R6 offer after last beat", OW'(out_valid), 1);
        to_drive();
        to_sample();
        chk(!out_valid, "R6 slot released", OW'(out_valid), 0);
        to_drive();

        // Interleaved IDs completing out of request order
        issue(1, 2); issue(2, 1); issue(5, 0);
        push_exp(5, 1); push_exp(2, 2); push_exp(1, 3);
        beat(1, 0, 0); beat(2, 0, 0); beat(5, 0, 1);
        beat(1, 1, 0); beat(2, 1, 1); beat(1, 2, 1);
        repeat (3) to_drive();

        // Repeated ID refused while outstanding
        issue(7, 1);
        probe(7, 1'b0, "R3 same id refused");
        probe(8, 1'b1, "R3 other id accepted");
        push_exp(7, 2);
        beat(7, 0, 0); beat(7, 1, 1);
        repeat (3) to_drive();
        probe(7, 1'b1, "R3 id reusable after hand-over");

        // Full table and lowest-slot priority
        out_ready = 1'b0;
        issue(1, 0); issue(2, 0); issue(3, 1); issue(4, 0);
        probe(9, 1'b0, "R2 full table refuses");
        beat(4, 0, 1);
        to_sample();
        chk(out_valid && out_id == 4'd4, "R7 only slot 3 done", OW'(out_id), 4);
        to_drive();
        beat(2, 0, 1);
        to_sample();
        chk(out_id == 4'd2, "R7 slot 1 before slot 3", OW'(out_id), 2);
        to_drive();
        beat(3, 0, 0); beat(3, 1, 1);
        beat(1, 0, 1);
        to_sample();
        chk(out_id == 4'd1, "R7 slot 0 first", OW'(out_id), 1);
        to_drive();
        probe(9, 1'b0, "R2 completed slots still occupy");
        push_exp(1, 1); push_exp(2, 1); push_exp(3, 2); push_exp(4, 1);
        out_ready = 1'b1;
        repeat (6) to_drive();
        to_sample();
        chk(!out_valid, "R7 all drained", OW'(out_valid), 0);
        to_drive();

        // Stray beat
        to_sample();
        chk(!err_sticky, "R8 flag low before stray", OW'(err_sticky), 0);
        to_drive();
        beat(12, 0, 1);
        to_sample();
        chk(err_sticky, "R8 stray raises flag", OW'(err_sticky), 1);
        chk(!out_valid, "R8 stray not offered", OW'(out_valid), 0);
        to_drive();

        // Early last marker
        do_reset();
        check_idle("R1 again");
        issue(6, 2);
        beat(6, 0, 0); beat(6, 1, 1);
        to_sample();
        chk(err_sticky, "R9 early last flagged", OW'(err_sticky), 1);
        chk(!out_valid, "R9 early burst dropped", OW'(out_valid), 0);
        to_drive();
        probe(6, 1'b1, "R9 early slot freed");

        // Missing last marker
        do_reset();
        issue(6, 1);
        beat(6, 0, 0); beat(6, 1, 0);
        to_sample();
        chk(err_sticky, "R9 missing last flagged", OW'(err_sticky), 1);
        chk(!out_valid, "R9 late burst dropped", OW'(out_valid), 0);
        to_drive();
        probe(6, 1'b1, "R9 late slot freed");

        // Flag persists while traffic continues
        repeat (5) to_drive();
        push_exp(2, 1);
        issue(2, 0);
        beat(2, 0, 1);
        to_sample();
        chk(err_sticky, "R10 flag persists", OW'(err_sticky), 1);
        chk(out_valid, "R10 traffic continues", OW'(out_valid), 1);
        to_drive();
        repeat (3) to_drive();
        chk(exp_id.size() == 0, "R6 all expected bursts seen", OW'(exp_id.size()), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 0);
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule